// File: doc/BRIEF.md
# Supervisor Mode Controller with Guarded Debug Entry

This block is the mode state machine of a supervisory companion chip that looks after a microcontroller. It tracks power-up, a timed normal-request window, normal operation with the watchdog running, a set of debug modes in which the watchdog is switched off, and the return from low-power debug states on a wake event. It drives a reset request to the microcontroller whenever a timed window runs out without being served.

The block sees register traffic as already decoded writes and reads: a strobe, a 4-bit register address and 4-bit data, as if the serial frame had been split elsewhere. Time is counted with a 1 ms tick. Turning the watchdog off is deliberately hard. A battery-fail flag, set only by power-on reset, allows a short write sequence (timer-1 write, arming write, debug-select write). That sequence must complete within the 350-tick window opened by the normal-request mode. Reading the mode control register clears the flag, which closes the debug path until the next power-on.

Top module: `supv_mode_ctrl`

## Requirements
- R1: After power-on reset (`rst_n` low), `mode` is 0 (normal request), `bat_flag` is 1, and `rst_req` and `wdog_en` are 0.
- R2: In normal request with no timer-1 write, the 350th tick after entry moves `mode` to 2 (reset). Reset lasts exactly 4 ticks, then `mode` returns to 0 with a fresh 350-tick window.
- R3: A write to register address 6 (timer-1) in normal request moves `mode` to 1 (normal). No periodic reset follows after that.
- R4: In normal mode with `bat_flag` set and the window still open, a write of data 0000 to register address 1 (mode control) arms debug entry. A following mode-control write whose low three bits are 101 moves `mode` to 3 (normal debug).
- R5: If debug entry is armed and the select write has not arrived by the end of the 350-tick window, `mode` goes to 2 and then back to 0. Without arming, the window's end leaves normal mode alone, and later arming writes have no debug effect.
- R6: In normal debug (3) or standby debug (4), a mode-control write of 0000 returns `mode` to 1.
- R7: From modes 3 or 4, mode-control low bits 110 select standby debug (4), 111 select stop debug (5) and 100 select sleep (6). A wake in mode 5 or 6 reached from debug returns `mode` to 0. In that window, low bits 101 or 110 go straight to mode 3 or 4. Otherwise the window's end gives a reset.
- R8: A read strobe at register address 1 clears `bat_flag` on the next cycle, and nothing but power-on reset sets it again. With the flag clear, a mode-control write of 0000 in normal mode leaves `mode` at 1, and a later 101 write is ignored.
- R9: Writes to other addresses, codes that match no transition from the current mode, and a wake outside modes 5 and 6 leave `mode` unchanged.
- R10: `wdog_en` is 1 exactly while `mode` is 1. `rst_req` is 1 exactly while `mode` is 2.
- R11: In normal mode, mode-control low bits 100 enter sleep (6). A wake then returns to 0 without a debug path, so a 101 write in that window is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low power-on reset |
| tick_ms | input | 1 | One-cycle pulse every millisecond |
| wake | input | 1 | Wake event from a low-power mode |
| wr_vld | input | 1 | Decoded register write strobe |
| wr_addr | input | 4 | Register address of the write |
| wr_data | input | 4 | Write data |
| rd_vld | input | 1 | Decoded register read strobe |
| rd_addr | input | 4 | Register address of the read |
| rst_req | output | 1 | Reset request to the microcontroller |
| wdog_en | output | 1 | Software watchdog enabled |
| mode | output | 3 | Current mode code (0..6) |
| bat_flag | output | 1 | Battery-fail flag, also the mode-control read value |

## Verification
The debug-entry sequence is driven in its complete, in-time form, with the select write missing, with the arming write coming after the window has closed, and after the flag has been read away. This shows whether the flag and the window each gate the path on their own. Idle power-up runs that are held for the full window, plus a second window after the reset, show whether the tick count and the reload on each normal-request entry are right. The low-power paths are tried from normal mode and from debug, so that a wake which re-opens debug can be told apart from one that does not.

// File: rtl/supv_pkg.sv
// Package: shared types of the supervisor mode controller.
// Assumes mode codes are fixed by the external register view.
package supv_pkg;
    localparam int MODE_W = 3;

    typedef enum logic [MODE_W-1:0] {
        M_NREQ  = 3'd0,
        M_NORM  = 3'd1,
        M_RST   = 3'd2,
        M_NDBG  = 3'd3,
        M_SDBG  = 3'd4,
        M_STOP  = 3'd5,
        M_SLEEP = 3'd6
    } mode_e;

    typedef enum logic [2:0] {
        A_NONE,
        A_ZERO,
        A_NDBG,
        A_SDBG,
        A_STOP,
        A_SLEEP
    } mcr_act_e;

    typedef struct packed {
        logic     tim1;
        logic     mcr;
        mcr_act_e act;
    } cmd_t;
endpackage

// File: rtl/supv_wr_decode.sv
// Module: turns decoded register strobes into mode commands.
// Assumes DATA_W >= 4; only the low four data bits are meaningful.
module supv_wr_decode
    import supv_pkg::*;
#(
    parameter int ADDR_W    = 4,
    parameter int DATA_W    = 4,
    parameter int MCR_ADDR  = 1,
    parameter int TIM1_ADDR = 6
) (
    input  logic              wr_vld,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              rd_vld,
    input  logic [ADDR_W-1:0] rd_addr,
    output cmd_t              cmd,
    output logic              flag_rd
);
    localparam logic [ADDR_W-1:0] MCR_A  = ADDR_W'(MCR_ADDR);
    localparam logic [ADDR_W-1:0] TIM1_A = ADDR_W'(TIM1_ADDR);

    // Classify the write data of a mode-control write.
    always_comb begin
        cmd.tim1 = wr_vld && (wr_addr == TIM1_A);
        cmd.mcr  = wr_vld && (wr_addr == MCR_A);
        if (wr_data[3:0] == 4'b0000) begin
            cmd.act = A_ZERO;
        end else begin
            unique case (wr_data[2:0])
                3'b101:  cmd.act = A_NDBG;
                3'b110:  cmd.act = A_SDBG;
                3'b111:  cmd.act = A_STOP;
                3'b100:  cmd.act = A_SLEEP;
                default: cmd.act = A_NONE;
            endcase
        end
    end

    // Mode-control reads are the only reads that matter here.
    assign flag_rd = rd_vld && (rd_addr == MCR_A);
endmodule

// File: rtl/supv_tick_timer.sv
// Module: one down-counter of millisecond ticks, shared by the
// normal-request window and the reset pulse; the two never overlap.
// Assumes tick is a one-cycle pulse; a load beats a tick in the same cycle.
module supv_tick_timer #(
    parameter int WIN_TICKS = 350,
    parameter int RST_TICKS = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic load_win,
    input  logic load_rst,
    output logic open,
    output logic expire
);
    localparam int MAXV = (WIN_TICKS > RST_TICKS) ? WIN_TICKS : RST_TICKS;
    localparam int CW   = $clog2(MAXV + 1);

    logic [CW-1:0] cnt_q;

    // Reload on mode entry, otherwise count ticks down to zero.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= CW'(WIN_TICKS);
        end else if (load_win) begin
            cnt_q <= CW'(WIN_TICKS);
        end else if (load_rst) begin
            cnt_q <= CW'(RST_TICKS);
        end else if (tick && (cnt_q != '0)) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign open   = (cnt_q != '0);
    assign expire = tick && (cnt_q == CW'(1));
endmodule

// File: rtl/supv_fail_flag.sv
// Module: battery-fail flag, set only by power-on reset, cleared by a read.
// Assumes rst_n stands for a true power-on event.
module supv_fail_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    output logic flag
);
    // Hold the flag until the first mode-control read.
    always_ff @(posedge clk) begin
        if (!rst_n)   flag <= 1'b1;
        else if (clr) flag <= 1'b0;
    end

    a_r8_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> !flag);
    a_r8_never_sets: assert property (@(posedge clk) disable iff (!rst_n)
        !$rose(flag));
endmodule

// File: rtl/supv_mode_fsm.sv
// Module: mode state machine with the guarded debug-entry path.
// Assumes expire/open come from a timer reloaded through load_win and
// load_rst; when a write and an expiry meet in one cycle, the expiry wins.
module supv_mode_fsm
    import supv_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  cmd_t  cmd,
    input  logic  wake,
    input  logic  flag,
    input  logic  win_open,
    input  logic  expire,
    output mode_e mode,
    output logic  load_win,
    output logic  load_rst
);
    mode_e mode_q, mode_d;
    logic  armed_q, armed_d;
    logic  sess_q, sess_d;

    // Next-state and side-flag logic for every mode.
    always_comb begin
        mode_d  = mode_q;
        armed_d = armed_q;
        sess_d  = sess_q;
        unique case (mode_q)
            M_NREQ: begin
                if (expire) begin
                    mode_d = M_RST;  armed_d = 1'b0; sess_d = 1'b0;
                end else if (cmd.tim1) begin
                    mode_d = M_NORM; sess_d = 1'b0;
                end else if (sess_q && cmd.mcr && cmd.act == A_NDBG) begin
                    mode_d = M_NDBG;
                end else if (sess_q && cmd.mcr && cmd.act == A_SDBG) begin
                    mode_d = M_SDBG;
                end
            end
            M_NORM: begin
                if (armed_q && expire) begin
                    mode_d = M_RST;  armed_d = 1'b0; sess_d = 1'b0;
                end else if (cmd.mcr) begin
                    if (cmd.act == A_ZERO && flag && win_open && !armed_q) begin
                        armed_d = 1'b1;
                    end else if (cmd.act == A_NDBG && armed_q && win_open) begin
                        mode_d = M_NDBG; armed_d = 1'b0; sess_d = 1'b1;
                    end else if (cmd.act == A_SLEEP) begin
                        mode_d = M_SLEEP; armed_d = 1'b0; sess_d = 1'b0;
                    end
                end
            end
            M_RST: begin
                if (expire) begin
                    mode_d = M_NREQ; armed_d = 1'b0; sess_d = 1'b0;
                end
            end
            M_NDBG, M_SDBG: begin
                if (cmd.mcr) begin
                    unique case (cmd.act)
                        A_ZERO:  begin mode_d = M_NORM; sess_d = 1'b0; end
                        A_NDBG:  mode_d = M_NDBG;
                        A_SDBG:  mode_d = M_SDBG;
                        A_STOP:  mode_d = M_STOP;
                        A_SLEEP: mode_d = M_SLEEP;
                        default: mode_d = mode_q;
                    endcase
                end
            end
            M_STOP, M_SLEEP: begin
                if (wake) mode_d = M_NREQ;
            end
            default: begin
                mode_d = M_NREQ; armed_d = 1'b0; sess_d = 1'b0;
            end
        endcase
    end

    // State registers; power-on lands in normal request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q  <= M_NREQ;
            armed_q <= 1'b0;
            sess_q  <= 1'b0;
        end else begin
            mode_q  <= mode_d;
            armed_q <= armed_d;
            sess_q  <= sess_d;
        end
    end

    assign mode     = mode_q;
    assign load_win = (mode_d == M_NREQ) && (mode_q != M_NREQ);
    assign load_rst = (mode_d == M_RST)  && (mode_q != M_RST);

    a_r2_window_timeout: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == M_NREQ && expire) |=> mode_q == M_RST);
    a_r3_timer1_serves: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == M_NREQ && !expire && cmd.tim1) |=> mode_q == M_NORM);
    a_r5_armed_timeout: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == M_NORM && armed_q && expire) |=> mode_q == M_RST);
    a_r6_leave_debug: assert property (@(posedge clk) disable iff (!rst_n)
        ((mode_q == M_NDBG || mode_q == M_SDBG) && cmd.mcr && cmd.act == A_ZERO)
        |=> mode_q == M_NORM);
    a_r7_wake_return: assert property (@(posedge clk) disable iff (!rst_n)
        ((mode_q == M_STOP || mode_q == M_SLEEP) && wake) |=> mode_q == M_NREQ);
endmodule

// File: rtl/supv_mode_ctrl.sv
// Module: top of the supervisor mode controller.
// Assumes writes and reads arrive already decoded from the serial frame
// and that tick_ms is a one-cycle pulse in the clk domain.
module supv_mode_ctrl
    import supv_pkg::*;
#(
    parameter int ADDR_W    = 4,
    parameter int DATA_W    = 4,
    parameter int MCR_ADDR  = 1,
    parameter int TIM1_ADDR = 6,
    parameter int WIN_TICKS = 350,
    parameter int RST_TICKS = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_ms,
    input  logic              wake,
    input  logic              wr_vld,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              rd_vld,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic              rst_req,
    output logic              wdog_en,
    output logic [MODE_W-1:0] mode,
    output logic              bat_flag
);
    cmd_t  cmd;
    logic  flag_rd, win_open, expire, load_win, load_rst;
    mode_e mode_s;

    supv_wr_decode #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W),
        .MCR_ADDR(MCR_ADDR), .TIM1_ADDR(TIM1_ADDR)
    ) u_dec (
        .wr_vld(wr_vld), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_vld(rd_vld), .rd_addr(rd_addr),
        .cmd(cmd), .flag_rd(flag_rd)
    );

    supv_tick_timer #(.WIN_TICKS(WIN_TICKS), .RST_TICKS(RST_TICKS)) u_tmr (
        .clk(clk), .rst_n(rst_n), .tick(tick_ms),
        .load_win(load_win), .load_rst(load_rst),
        .open(win_open), .expire(expire)
    );

    supv_fail_flag u_flag (
        .clk(clk), .rst_n(rst_n), .clr(flag_rd), .flag(bat_flag)
    );

    supv_mode_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .cmd(cmd), .wake(wake), .flag(bat_flag),
        .win_open(win_open), .expire(expire),
        .mode(mode_s), .load_win(load_win), .load_rst(load_rst)
    );

    // Outputs follow the registered mode directly.
    assign mode    = mode_s;
    assign rst_req = (mode_s == M_RST);
    assign wdog_en = (mode_s == M_NORM);
endmodule

// File: tb/supv_mode_ctrl_tb.sv
module supv_mode_ctrl_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick_ms = 1'b0, wake = 1'b0, wr_vld = 1'b0, rd_vld = 1'b0;
    logic [3:0] wr_addr = '0, wr_data = '0, rd_addr = '0;
    logic       rst_req, wdog_en, bat_flag;
    logic [2:0] mode;
    int         n_chk = 0, n_bad = 0;

    always #2.5 clk = ~clk;

    supv_mode_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .tick_ms(tick_ms), .wake(wake),
        .wr_vld(wr_vld), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_vld(rd_vld), .rd_addr(rd_addr),
        .rst_req(rst_req), .wdog_en(wdog_en), .mode(mode), .bat_flag(bat_flag)
    );

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: got %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk); rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic wr(input logic [3:0] a, input logic [3:0] d);
        @(negedge clk); wr_vld = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk); wr_vld = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a);
        @(negedge clk); rd_vld = 1'b1; rd_addr = a;
        @(negedge clk); rd_vld = 1'b0;
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); tick_ms = 1'b1;
            @(negedge clk); tick_ms = 1'b0;
        end
    endtask

    task automatic pulse_wake();
        @(negedge clk); wake = 1'b1;
        @(negedge clk); wake = 1'b0;
    endtask

    task automatic enter_ndbg();
        wr(4'd6, 4'b0000);
        wr(4'd1, 4'b0000);
        wr(4'd1, 4'b1101);
    endtask

    task automatic t_reset();
        do_reset();
        chk("R1 mode", mode, 0);
        chk("R1 flag", bat_flag, 1);
        chk("R1 rst_req", rst_req, 0);
        chk("R1 wdog_en", wdog_en, 0);
    endtask

    task automatic t_window();
        do_reset();
        ticks(349);
        chk("R2 before expiry", mode, 0);
        ticks(1);
        chk("R2 reset entered", mode, 2);
        chk("R10 rst_req high", rst_req, 1);
        ticks(3);
        chk("R2 reset held", mode, 2);
        ticks(1);
        chk("R2 reset ended", mode, 0);
        chk("R10 rst_req low", rst_req, 0);
        ticks(349);
        chk("R2 reloaded window", mode, 0);
        ticks(1);
        chk("R2 second expiry", mode, 2);
        ticks(4);
    endtask

    task automatic t_normal();
        do_reset();
        ticks(100);
        wr(4'd6, 4'b0000);
        chk("R3 normal", mode, 1);
        chk("R10 wdog on", wdog_en, 1);
        ticks(400);
        chk("R3 no reset later", mode, 1);
        wr(4'd1, 4'b0101);
        chk("R9 unarmed select", mode, 1);
        pulse_wake();
        chk("R9 wake in normal", mode, 1);
        wr(4'd2, 4'b0111);
        chk("R9 other address", mode, 1);
    endtask

    task automatic t_debug();
        do_reset();
        wr(4'd6, 4'b0000);
        wr(4'd1, 4'b0000);
        chk("R4 armed stays normal", mode, 1);
        wr(4'd1, 4'b1101);
        chk("R4 normal debug", mode, 3);
        chk("R10 wdog off", wdog_en, 0);
        ticks(500);
        chk("R4 debug holds", mode, 3);
        wr(4'd1, 4'b0000);
        chk("R6 leave debug", mode, 1);
        chk("R6 wdog back", wdog_en, 1);
        wr(4'd1, 4'b0101);
        chk("R9 select after leave", mode, 1);
    endtask

    task automatic t_arm_timeout();
        do_reset();
        ticks(100);
        wr(4'd6, 4'b0000);
        wr(4'd1, 4'b0000);
        ticks(249);
        chk("R5 armed in window", mode, 1);
        ticks(1);
        chk("R5 armed expiry reset", mode, 2);
        ticks(4);
        chk("R5 back to request", mode, 0);
    endtask

    task automatic t_late_arm();
        do_reset();
        wr(4'd6, 4'b0000);
        ticks(350);
        chk("R5 unarmed expiry", mode, 1);
        wr(4'd1, 4'b0000);
        wr(4'd1, 4'b0101);
        chk("R5 late arm no debug", mode, 1);
    endtask

    task automatic t_lowpower();
        do_reset();
        enter_ndbg();
        wr(4'd1, 4'b0110);
        chk("R7 standby debug", mode, 4);
        wr(4'd1, 4'b0111);
        chk("R7 stop debug", mode, 5);
        wr(4'd1, 4'b0101);
        chk("R9 write in stop", mode, 5);
        pulse_wake();
        chk("R7 wake to request", mode, 0);
        wr(4'd1, 4'b0110);
        chk("R7 direct standby", mode, 4);
        wr(4'd1, 4'b0100);
        chk("R7 sleep from debug", mode, 6);
        pulse_wake();
        chk("R7 wake from sleep", mode, 0);
        ticks(350);
        chk("R7 missed window reset", mode, 2);
        ticks(4);
        wr(4'd1, 4'b0101);
        chk("R7 session dropped", mode, 0);
    endtask

    task automatic t_flag_read();
        do_reset();
        rd(4'd3);
        chk("R8 other read keeps flag", bat_flag, 1);
        rd(4'd1);
        chk("R8 read clears flag", bat_flag, 0);
        wr(4'd6, 4'b0000);
        wr(4'd1, 4'b0000);
        chk("R8 zero write ordinary", mode, 1);
        wr(4'd1, 4'b0101);
        chk("R8 no debug after read", mode, 1);
        chk("R8 flag stays clear", bat_flag, 0);
    endtask

    task automatic t_sleep_normal();
        do_reset();
        wr(4'd6, 4'b0000);
        wr(4'd1, 4'b0100);
        chk("R11 sleep from normal", mode, 6);
        chk("R11 wdog off in sleep", wdog_en, 0);
        pulse_wake();
        chk("R11 wake to request", mode, 0);
        wr(4'd1, 4'b0101);
        chk("R11 no debug path", mode, 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: got 0 expected 1 (run did not finish)");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        t_reset();
        t_window();
        t_normal();
        t_debug();
        t_arm_timeout();
        t_late_arm();
        t_lowpower();
        t_flag_read();
        t_sleep_normal();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule